// File: doc/BRIEF.md
# Receive Flow Control and Status for a Two-Channel Serial Port

This block sits behind the bit-level receivers of a two-channel serial port. Each channel has a small receive FIFO. A character enters it through a push strobe when the receiver finishes a frame. It leaves through a valid/ready pop interface, which is the processor reading the receive buffer. The consumer may hold ready low for as long as it likes. The head character then stays on the pop data lines until it is taken. The push side has no ready signal, because a receiver cannot stall the line. A character pushed into a full FIFO is lost, and a sticky overrun flag records the loss.

Each channel drives an active-low request-to-send output. There are two ways to control it:

- **Automatic mode:** RTS is dropped when a start bit arrives while the FIFO is full. It is raised again as soon as a slot frees up.
- **Manual mode:** RTS follows one bit of an output-port register.

A per-channel select bit decides what the channel's bit in the shared interrupt status byte shows: "character waiting" or "FIFO full". An 8-bit interrupt vector register completes the register set. The mode registers are locked while the port is stopped.

The register set is reached through a 2-bit address:

| Address | Register |
|---|---|
| 0 | Mode, channel A |
| 1 | Mode, channel B |
| 2 | Interrupt vector |
| 3 | Output port |

Mode register fields:

| Bit | Field |
|---|---|
| bit 0 | Receive-side automatic RTS |
| bit 1 | Full-select |
| bit 2 | Transmit-side RTS control enable |

Top module: `rx_flow_ctl`

## Requirements
- R1: With automatic control active, a start-bit pulse on a channel whose FIFO is full, with no pop in the same cycle, drives that channel's rts_n high on the next clock. A full FIFO with no start pulse leaves RTS asserted (low).
- R2: With automatic control active, rts_n is low in the cycle after any cycle in which the FIFO is not full.
- R3: If mode bit 0 and mode bit 2 are both set, automatic control is off for that channel, and RTS behaves as in R4.
- R4: With automatic control off, rts_n of channel A is the inverse of output-port bit 0, and rts_n of channel B is the inverse of output-port bit 1. It follows the register one cycle after the register changes.
- R5: With mode bit 1 clear, isr_rx bit 1 (channel A) and bit 5 (channel B) are 1 while the FIFO holds at least one character. The bit sets one cycle after a push and clears one cycle after the read that empties the FIFO.
- R6: With mode bit 1 set, the same status bit is 1 exactly while the FIFO is full. It sets when the last slot fills and clears when a slot is freed, each one cycle after the event. All other isr_rx bits are 0.
- R7: The interrupt vector register (address 2) resets to 0x0F and reads back what was written.
- R8: Mode registers reset to 0. While mod_stop is 1, writes to addresses 0 and 1 are ignored and reads from them return 0.
- R9: Each FIFO holds DEPTH characters (default 3), delivered in arrival order. A push into a full FIFO without a simultaneous pop drops the character and sets that channel's overrun bit until reset.
- R10: A push and a pop in the same cycle on a full FIFO accept the new character and leave the occupancy unchanged.
- R11: During reset, rts_n is high on both channels and isr_rx is 0.
- R12: pop_valid is high while the FIFO is non-empty. pop_data holds the head character unchanged until pop_valid and pop_ready are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_stop | input | 1 | Port stopped; locks the mode registers |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0/1 mode A/B, 2 vector, 3 output port |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for cfg_addr |
| start_det | input | 2 | Valid start-bit pulse per channel |
| push_valid | input | 2 | Character-complete strobe per channel |
| push_data | input | 2*DW | Received characters, channel A in the low byte |
| pop_valid | output | 2 | Receive buffer holds a character |
| pop_ready | input | 2 | Receive buffer read |
| pop_data | output | 2*DW | Head character per channel |
| rts_n | output | 2 | Active-low request-to-send per channel |
| isr_rx | output | 8 | Receiver bits of the interrupt status byte |
| overrun | output | 2 | Sticky overrun per channel |

## Verification
A wrong FIFO count shows up at the ports within one clock. It appears either as a status bit that disagrees with the number of characters the bench has pushed and not yet popped, or as a FIFO-full state that is wrong for the next start pulse. A stuck or wrongly cleared drop flag on RTS is visible on rts_n one cycle after a start pulse or a pop. Pointer errors surface as soon as the scoreboard compares the next popped character, and the check that the queue is empty after draining catches a dropped character that was stored anyway.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  localparam int NCH = 2;
  localparam logic [7:0] VEC_RESET = 8'h0F;

  // per-channel mode fields
  typedef struct packed {
    logic tx_auto;   // bit 2
    logic full_sel;  // bit 1
    logic rx_auto;   // bit 0
  } mode_t;

  typedef enum logic [1:0] {
    A_MODE_A = 2'd0,
    A_MODE_B = 2'd1,
    A_VEC    = 2'd2,
    A_OPORT  = 2'd3
  } cfg_addr_e;

  // status byte position of a channel's receiver bit
  function automatic int isr_pos(int ch);
    return ch * 4 + 1;
  endfunction
endpackage

// File: rtl/rxfc_fifo.sv
module rxfc_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop_ready,
  output logic          pop_valid,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          full_nx,
  output logic          empty_nx,
  output logic          overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);
  localparam logic [AW-1:0] PLAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt, cnt_nx;
  logic          empty, do_pop, do_push;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CMAX);
  assign pop_valid = !empty;
  assign dout      = mem[rd_ptr];
  assign do_pop    = pop_ready && !empty;
  assign do_push   = push && (!full || do_pop);
  assign cnt_nx    = cnt + CW'(do_push) - CW'(do_pop);
  assign full_nx   = (cnt_nx == CMAX);
  assign empty_nx  = (cnt_nx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      if (do_push) wr_ptr <= (wr_ptr == PLAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PLAST) ? '0 : rd_ptr + 1'b1;
      if (push && full && !do_pop) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/rxfc_chan.sv
module rxfc_chan
  import rxfc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  op_bit,
  input  logic  start,
  input  logic  full,
  input  logic  full_nx,
  input  logic  empty_nx,
  output logic  auto_en,
  output logic  rts_n,
  output logic  isr_bit
);
  logic drop_q, drop_nx;

  // both sides requesting RTS control is illegal: fall back to manual
  assign auto_en = mode.rx_auto && !mode.tx_auto;
  // drop on start bit while full; hold until a slot frees
  assign drop_nx = auto_en && ((start && full) || drop_q) && full_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q  <= 1'b0;
      rts_n   <= 1'b1;
      isr_bit <= 1'b0;
    end else begin
      drop_q  <= drop_nx;
      rts_n   <= auto_en ? drop_nx : !op_bit;
      isr_bit <= mode.full_sel ? full_nx : !empty_nx;
    end
  end
endmodule

// File: rtl/rxfc_regs.sv
module rxfc_regs
  import rxfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop,
  input  logic                we,
  input  logic [1:0]          addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  output mode_t [NCH-1:0]     mode,
  output logic [7:0]          vec,
  output logic [7:0]          oport
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= '0;
      vec   <= VEC_RESET;
      oport <= '0;
    end else if (we) begin
      unique case (cfg_addr_e'(addr))
        A_MODE_A: if (!stop) mode[0] <= mode_t'(wdata[2:0]);
        A_MODE_B: if (!stop) mode[1] <= mode_t'(wdata[2:0]);
        A_VEC:    vec   <= wdata;
        A_OPORT:  oport <= wdata;
      endcase
    end
  end

  always_comb begin
    unique case (cfg_addr_e'(addr))
      A_MODE_A: rdata = stop ? 8'h00 : {5'b0, mode[0]};
      A_MODE_B: rdata = stop ? 8'h00 : {5'b0, mode[1]};
      A_VEC:    rdata = vec;
      A_OPORT:  rdata = oport;
    endcase
  end
endmodule

// File: rtl/rx_flow_ctl.sv
module rx_flow_ctl
  import rxfc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_stop,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [NCH-1:0]    start_det,
  input  logic [NCH-1:0]    push_valid,
  input  logic [NCH*DW-1:0] push_data,
  output logic [NCH-1:0]    pop_valid,
  input  logic [NCH-1:0]    pop_ready,
  output logic [NCH*DW-1:0] pop_data,
  output logic [NCH-1:0]    rts_n,
  output logic [7:0]        isr_rx,
  output logic [NCH-1:0]    overrun
);
  mode_t [NCH-1:0] mode;
  logic [7:0]      vec, oport;
  logic [NCH-1:0]  fifo_full, full_nx, empty_nx, auto_en, isr_bits, sel_v;

  rxfc_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .stop  (mod_stop),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .mode  (mode),
    .vec   (vec),
    .oport (oport)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sel_v[c] = mode[c].full_sel;

    rxfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_valid[c]),
      .din       (push_data[c*DW +: DW]),
      .pop_ready (pop_ready[c]),
      .pop_valid (pop_valid[c]),
      .dout      (pop_data[c*DW +: DW]),
      .full      (fifo_full[c]),
      .full_nx   (full_nx[c]),
      .empty_nx  (empty_nx[c]),
      .overrun   (overrun[c])
    );

    rxfc_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode[c]),
      .op_bit   (oport[c]),
      .start    (start_det[c]),
      .full     (fifo_full[c]),
      .full_nx  (full_nx[c]),
      .empty_nx (empty_nx[c]),
      .auto_en  (auto_en[c]),
      .rts_n    (rts_n[c]),
      .isr_bit  (isr_bits[c])
    );
  end

  always_comb begin
    isr_rx = '0;
    for (int c = 0; c < NCH; c++) isr_rx[isr_pos(c)] = isr_bits[c];
  end
endmodule

// File: rtl/rx_flow_ctl_chk.sv
module rx_flow_ctl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mod_stop,
  input logic           cfg_we,
  input logic [1:0]     cfg_addr,
  input logic [5:0]     mode_bits,
  input logic [NCH-1:0] auto_en,
  input logic [NCH-1:0] sel_v,
  input logic [NCH-1:0] op_bits,
  input logic [NCH-1:0] start_det,
  input logic [NCH-1:0] push_valid,
  input logic [NCH-1:0] pop_valid,
  input logic [NCH-1:0] pop_ready,
  input logic [NCH-1:0] fifo_full,
  input logic [NCH-1:0] rts_n,
  input logic [7:0]     isr_rx,
  input logic [NCH-1:0] overrun
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en[c] && start_det[c] && fifo_full[c] && !(pop_valid[c] && pop_ready[c]) |=> rts_n[c]); // R1
    AST_RTS_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en[c] && !fifo_full[c] |=> !rts_n[c]); // R2
    AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en[c] |=> rts_n[c] == !$past(op_bits[c])); // R4
    AST_ISR_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_v[c] |=> isr_rx[c*4+1] == pop_valid[c]); // R5
    AST_ISR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      sel_v[c] |=> isr_rx[c*4+1] == fifo_full[c]); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid[c] && fifo_full[c] && !(pop_valid[c] && pop_ready[c]) |=> overrun[c]); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[c] |=> overrun[c]); // R9
  end

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mod_stop && cfg_we && !cfg_addr[1] |=> $stable(mode_bits)); // R8
  AST_ISR_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rx & 8'hDD) == 8'h00); // R6
endmodule

bind rx_flow_ctl rx_flow_ctl_chk #(.NCH(2)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_stop   (mod_stop),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .mode_bits  ({mode[1], mode[0]}),
  .auto_en    (auto_en),
  .sel_v      (sel_v),
  .op_bits    (oport[1:0]),
  .start_det  (start_det),
  .push_valid (push_valid),
  .pop_valid  (pop_valid),
  .pop_ready  (pop_ready),
  .fifo_full  (fifo_full),
  .rts_n      (rts_n),
  .isr_rx     (isr_rx),
  .overrun    (overrun)
);

// File: tb/test_rx_flow_ctl.sv
`timescale 1ns/1ps
module test_rx_flow_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_stop = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic [1:0]  start_det = '0, push_valid = '0, pop_ready = '0;
  logic [15:0] push_data = '0;
  logic [1:0]  pop_valid, rts_n, overrun;
  logic [15:0] pop_data;
  logic [7:0]  isr_rx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] q0[$];
  logic [7:0] q1[$];

  always #2.5 clk = ~clk;

  rx_flow_ctl i_rx_flow_ctl (
    .clk(clk), .rst_n(rst_n), .mod_stop(mod_stop), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .start_det(start_det), .push_valid(push_valid), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .rts_n(rts_n), .isr_rx(isr_rx), .overrun(overrun)
  );

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare every taken character with the scoreboard (R9, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pop_valid[0] && pop_ready[0]) begin
        if (q0.size() == 0) check_eq("R9 chA unexpected pop", int'(pop_data[7:0]), -1);
        else check_eq("R9 chA order", int'(pop_data[7:0]), int'(q0.pop_front()));
      end
      if (pop_valid[1] && pop_ready[1]) begin
        if (q1.size() == 0) check_eq("R9 chB unexpected pop", int'(pop_data[15:8]), -1);
        else check_eq("R9 chB order", int'(pop_data[15:8]), int'(q1.pop_front()));
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  task automatic read_reg(logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    settle();
    d = cfg_rdata;
  endtask

  // driver: push a character; kept ones go to the scoreboard
  task automatic push_char(int c, logic [7:0] d, bit keep);
    push_valid[c] = 1'b1;
    push_data[c*8 +: 8] = d;
    if (keep) begin
      if (c == 0) q0.push_back(d); else q1.push_back(d);
    end
    tick();
    push_valid[c] = 1'b0;
  endtask

  task automatic pop_one(int c);
    pop_ready[c] = 1'b1;
    tick();
    pop_ready[c] = 1'b0;
  endtask

  task automatic start_pulse(int c);
    start_det[c] = 1'b1;
    tick();
    start_det[c] = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) settle();
    check_eq("R11 rts_n in reset", int'(rts_n), 3);
    check_eq("R11 isr_rx in reset", int'(isr_rx), 0);
    read_reg(2'd2, rd);
    check_eq("R7 vector reset", int'(rd), 8'h0F);
    read_reg(2'd0, rd);
    check_eq("R8 mode A reset", int'(rd), 0);
    tick();
    rst_n = 1'b1;
    tick();

    // manual RTS from the output-port register
    cfg_write(2'd3, 8'h01); settle();
    check_eq("R4 op=01 rts_n", int'(rts_n), 2'b10);
    cfg_write(2'd3, 8'h02); settle();
    check_eq("R4 op=02 rts_n", int'(rts_n), 2'b01);

    // receiver-ready status and pop hold
    push_char(0, 8'h11, 1'b1); settle();
    check_eq("R5 isr A set on char", int'(isr_rx), 8'h02);
    check_eq("R12 pop_valid A", int'(pop_valid[0]), 1);
    tick(); settle();
    check_eq("R12 data held", int'(pop_data[7:0]), 8'h11);
    pop_one(0); settle();
    check_eq("R5 isr A clear on read", int'(isr_rx[1]), 0);

    // automatic RTS
    cfg_write(2'd0, 8'h01); settle();
    check_eq("R2 auto asserts", int'(rts_n[0]), 0);
    push_char(0, 8'h21, 1'b1);
    push_char(0, 8'h22, 1'b1);
    push_char(0, 8'h23, 1'b1); settle();
    check_eq("R1 full without start keeps RTS", int'(rts_n[0]), 0);
    start_pulse(0); settle();
    check_eq("R1 start while full drops RTS", int'(rts_n[0]), 1);
    push_char(0, 8'h24, 1'b0); settle();
    check_eq("R9 overrun set", int'(overrun[0]), 1);
    check_eq("R1 RTS stays dropped", int'(rts_n[0]), 1);
    pop_one(0); settle();
    check_eq("R2 RTS back after slot frees", int'(rts_n[0]), 0);

    // full-select status
    cfg_write(2'd0, 8'h03); settle();
    check_eq("R6 not full reads 0", int'(isr_rx[1]), 0);
    push_char(0, 8'h25, 1'b1); settle();
    check_eq("R6 full reads 1", int'(isr_rx[1]), 1);
    pop_one(0); settle();
    check_eq("R6 slot freed reads 0", int'(isr_rx[1]), 0);
    pop_one(0);
    pop_one(0); settle();
    check_eq("R9 drained A", int'(pop_valid[0]), 0);
    check_eq("R9 scoreboard A empty", q0.size(), 0);
    check_eq("R9 overrun sticky", int'(overrun[0]), 1);

    // illegal double control on B falls back to manual
    cfg_write(2'd1, 8'h05);
    push_char(1, 8'h31, 1'b1);
    push_char(1, 8'h32, 1'b1);
    push_char(1, 8'h33, 1'b1);
    start_pulse(1); settle();
    check_eq("R3 manual despite start while full", int'(rts_n[1]), 0);
    check_eq("R5 isr B set", int'(isr_rx), 8'h20);
    cfg_write(2'd3, 8'h00); settle();
    check_eq("R3 follows op bit", int'(rts_n[1]), 1);

    // simultaneous push and pop on a full FIFO
    cfg_write(2'd1, 8'h03); settle();
    check_eq("R6 isr B full", int'(isr_rx[5]), 1);
    push_valid[1] = 1'b1; push_data[15:8] = 8'h34; q1.push_back(8'h34);
    pop_ready[1] = 1'b1;
    tick();
    push_valid[1] = 1'b0; pop_ready[1] = 1'b0;
    settle();
    check_eq("R10 still full", int'(isr_rx[5]), 1);
    check_eq("R10 no overrun", int'(overrun[1]), 0);
    pop_one(1); pop_one(1); pop_one(1); settle();
    check_eq("R10 drained B", int'(pop_valid[1]), 0);
    check_eq("R10 scoreboard B empty", q1.size(), 0);

    // mode lock while stopped
    mod_stop = 1'b1;
    read_reg(2'd0, rd);
    check_eq("R8 read while stopped", int'(rd), 0);
    cfg_write(2'd0, 8'h00);
    mod_stop = 1'b0;
    read_reg(2'd0, rd);
    check_eq("R8 write ignored while stopped", int'(rd), 8'h03);

    // vector read/write
    cfg_write(2'd2, 8'hA5);
    read_reg(2'd2, rd);
    check_eq("R7 vector readback", int'(rd), 8'hA5);

    tick();
    finish_run();
  end
endmodule